// File: doc/BRIEF.md
# Trap Entry State Unit

This unit performs the privileged state update a processor core needs when it enters an exception handler. When the pipeline raises a synchronous fault, it presents the faulting program counter, a cause code and, for address faults, the offending virtual address. One clock later the unit has saved the return address in the correct save register and logged the cause. It has also moved the status word into exception mode, and it issues a one-cycle redirect with the handler address.

A debug request goes through the same path. It is gated by the current effective interrupt level. When accepted, it saves the pc and the old status word into the debug-level save registers and raises the status level to the debug level. Handler addresses come from static vectors. When relocation is configured, each vector is moved by the difference between a runtime vector-base register and the static default base. The status word and the vector base can also be written through a plain write port, as the core's special-register writes would do.

Top module: `trap_entry`

## Requirements
- R1: After reset the status word reads 0x10 (exception mode set, level 0, kernel), the vector base reads STATIC_BASE, every save and cause register reads zero, and redirect is low.
- R2: A general request with status bit 4 (exception mode) clear writes the pc to the level-1 save register. It selects VEC_USER when status bit 5 (user mode) is set and VEC_KERNEL otherwise.
- R3: A general request with status bit 4 set is a double fault. It targets VEC_DOUBLE and writes the pc to the double-fault save register when HAS_DBL_SAVE is 1, or to the level-1 save register when it is 0.
- R4: Every taken general request copies the cause code into the fault-cause register and sets status bit 4. The other status bits are left unchanged.
- R5: The fault-address register is written with vaddr only on a taken general request with vaddr-valid high. Otherwise it holds its value.
- R6: The effective level is status bits [3:0], raised to EXCM_LEVEL while bit 4 is set. A debug request is accepted only when the effective level is strictly below DBG_LEVEL. A refused debug request alone causes no redirect and no state change.
- R7: An accepted debug request writes the cause to the debug-cause register, the pc to the debug save pc and the old status word to the debug saved status. It sets status [3:0] to DBG_LEVEL and bit 4 to 1, keeps bit 5, and targets VEC_DEBUG.
- R8: When an accepted debug request and a general request arrive together, only the debug entry happens. The general cause, save and address registers keep their values.
- R9: With RELOC_EN set, the target is static vector minus STATIC_BASE plus the vector base, modulo 2^32. With RELOC_EN clear, the target is the static vector.
- R10: All updates appear on the outputs on the clock edge that samples the request. Redirect is high for exactly that one cycle, and only after a taken request.
- R11: The status and vector-base write ports take effect on the next edge. A taken request in the same cycle overrides the status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| exc_req_i | input | 1 | general fault request strobe |
| dbg_req_i | input | 1 | debug request strobe |
| fault_pc_i | input | XLEN | pc of the faulting instruction |
| cause_i | input | CAUSE_W | cause code |
| vaddr_i | input | XLEN | faulting virtual address |
| vaddr_vld_i | input | 1 | vaddr_i is meaningful |
| ps_wr_en_i | input | 1 | status word write enable |
| ps_wr_data_i | input | 6 | status word write data |
| vecbase_wr_en_i | input | 1 | vector base write enable |
| vecbase_wr_data_i | input | XLEN | vector base write data |
| redirect_o | output | 1 | one-cycle fetch redirect |
| target_pc_o | output | XLEN | handler address |
| ps_o | output | 6 | status word |
| epc1_o | output | XLEN | level-1 save pc |
| dbl_epc_o | output | XLEN | double-fault save pc (zero if not configured) |
| exc_cause_o | output | CAUSE_W | fault cause |
| exc_vaddr_o | output | XLEN | fault virtual address |
| dbg_cause_o | output | CAUSE_W | debug cause |
| dbg_epc_o | output | XLEN | debug-level save pc |
| dbg_eps_o | output | 6 | debug-level saved status |
| vecbase_o | output | XLEN | vector base |

## Verification
Every architectural register is a port, so a wrong internal decision shows up on the outputs on the edge right after the request. A misread status word gives a wrong vector and a wrong save register. A bad level comparison either redirects when it should not or leaves the debug registers stale. The bench sweeps all 64 status words against four request mixes, on one instance with relocation and a double-fault save register and on a second with neither. It predicts every register arithmetically and compares them all in the cycle after each request.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int PS_W        = 6;
  localparam int PS_LVL_W    = 4;
  localparam int PS_EXCM_BIT = 4;
  localparam int PS_UM_BIT   = 5;
  localparam logic [PS_W-1:0] PS_RESET = 6'b01_0000;

  typedef enum logic [2:0] {
    ENTRY_NONE,
    ENTRY_USER,
    ENTRY_KERNEL,
    ENTRY_DOUBLE,
    ENTRY_DEBUG
  } entry_kind_e;
endpackage

// File: rtl/trap_classify.sv
module trap_classify
  import trap_pkg::*;
#(
  parameter int unsigned DBG_LEVEL  = 6,
  parameter int unsigned EXCM_LEVEL = 3
) (
  input  logic            exc_req_i,
  input  logic            dbg_req_i,
  input  logic [PS_W-1:0] ps_i,
  output entry_kind_e     kind_o
);
  localparam logic [PS_LVL_W-1:0] DBG_LVL  = PS_LVL_W'(DBG_LEVEL);
  localparam logic [PS_LVL_W-1:0] EXCM_LVL = PS_LVL_W'(EXCM_LEVEL);

  logic [PS_LVL_W-1:0] eff_lvl;
  logic                dbg_ok;

  // effective level: field raised to the exception-mode floor
  always_comb begin
    eff_lvl = ps_i[PS_LVL_W-1:0];
    if (ps_i[PS_EXCM_BIT] && (eff_lvl < EXCM_LVL)) eff_lvl = EXCM_LVL;
  end

  assign dbg_ok = dbg_req_i && (eff_lvl < DBG_LVL);

  always_comb begin
    kind_o = ENTRY_NONE;
    if (dbg_ok)                   kind_o = ENTRY_DEBUG;
    else if (exc_req_i) begin
      if (ps_i[PS_EXCM_BIT])      kind_o = ENTRY_DOUBLE;
      else if (ps_i[PS_UM_BIT])   kind_o = ENTRY_USER;
      else                        kind_o = ENTRY_KERNEL;
    end
  end
endmodule

// File: rtl/trap_vector_sel.sv
module trap_vector_sel
  import trap_pkg::*;
#(
  parameter int unsigned     XLEN        = 32,
  parameter bit              RELOC_EN    = 1'b1,
  parameter logic [XLEN-1:0] STATIC_BASE = 32'h4000_0000,
  parameter logic [XLEN-1:0] VEC_KERNEL  = 32'h4000_0300,
  parameter logic [XLEN-1:0] VEC_USER    = 32'h4000_0340,
  parameter logic [XLEN-1:0] VEC_DOUBLE  = 32'h4000_03C0,
  parameter logic [XLEN-1:0] VEC_DEBUG   = 32'h4000_0280
) (
  input  entry_kind_e     kind_i,
  input  logic [XLEN-1:0] vecbase_i,
  output logic [XLEN-1:0] target_o
);
  logic [XLEN-1:0] static_vec;
  logic [XLEN-1:0] moved_vec;

  always_comb begin
    unique case (kind_i)
      ENTRY_USER:   static_vec = VEC_USER;
      ENTRY_KERNEL: static_vec = VEC_KERNEL;
      ENTRY_DOUBLE: static_vec = VEC_DOUBLE;
      ENTRY_DEBUG:  static_vec = VEC_DEBUG;
      default:      static_vec = '0;
    endcase
  end

  assign moved_vec = static_vec - STATIC_BASE + vecbase_i;
  assign target_o  = RELOC_EN ? moved_vec : static_vec;
endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
  import trap_pkg::*;
#(
  parameter int unsigned     XLEN         = 32,
  parameter int unsigned     CAUSE_W      = 6,
  parameter int unsigned     DBG_LEVEL    = 6,
  parameter bit              HAS_DBL_SAVE = 1'b1,
  parameter logic [XLEN-1:0] STATIC_BASE  = 32'h4000_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  entry_kind_e        kind_i,
  input  logic [XLEN-1:0]    target_i,
  input  logic [XLEN-1:0]    fault_pc_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    vaddr_i,
  input  logic               vaddr_vld_i,
  input  logic               ps_wr_en_i,
  input  logic [PS_W-1:0]    ps_wr_data_i,
  input  logic               vecbase_wr_en_i,
  input  logic [XLEN-1:0]    vecbase_wr_data_i,
  output logic               redirect_o,
  output logic [XLEN-1:0]    target_pc_o,
  output logic [PS_W-1:0]    ps_o,
  output logic [XLEN-1:0]    epc1_o,
  output logic [XLEN-1:0]    dbl_epc_o,
  output logic [CAUSE_W-1:0] exc_cause_o,
  output logic [XLEN-1:0]    exc_vaddr_o,
  output logic [CAUSE_W-1:0] dbg_cause_o,
  output logic [XLEN-1:0]    dbg_epc_o,
  output logic [PS_W-1:0]    dbg_eps_o,
  output logic [XLEN-1:0]    vecbase_o
);
  localparam logic [PS_LVL_W-1:0] DBG_LVL = PS_LVL_W'(DBG_LEVEL);

  logic [PS_W-1:0]    ps_q, ps_d;
  logic               ps_en;
  logic [XLEN-1:0]    epc1_q, vaddr_q, depc_q, vecbase_q, target_q;
  logic [CAUSE_W-1:0] cause_q, dcause_q;
  logic [PS_W-1:0]    deps_q;
  logic               redirect_q, redirect_d;
  logic               gen_hit, dbl_hit, dbg_hit;
  logic               epc1_en, cause_en, vaddr_en;

  // ---------------- next-state ----------------
  assign gen_hit = (kind_i == ENTRY_USER) || (kind_i == ENTRY_KERNEL) ||
                   (kind_i == ENTRY_DOUBLE);
  assign dbl_hit = (kind_i == ENTRY_DOUBLE);
  assign dbg_hit = (kind_i == ENTRY_DEBUG);

  assign epc1_en    = (gen_hit && !dbl_hit) || (dbl_hit && !HAS_DBL_SAVE);
  assign cause_en   = gen_hit;
  assign vaddr_en   = gen_hit && vaddr_vld_i;
  assign redirect_d = gen_hit || dbg_hit;

  always_comb begin
    ps_d  = ps_q;
    ps_en = ps_wr_en_i;
    if (ps_wr_en_i) ps_d = ps_wr_data_i;
    if (gen_hit) begin
      ps_en = 1'b1;
      ps_d  = ps_q;
      ps_d[PS_EXCM_BIT] = 1'b1;
    end else if (dbg_hit) begin
      ps_en = 1'b1;
      ps_d  = ps_q;
      ps_d[PS_LVL_W-1:0] = DBG_LVL;
      ps_d[PS_EXCM_BIT]  = 1'b1;
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q       <= PS_RESET;
      epc1_q     <= '0;
      cause_q    <= '0;
      vaddr_q    <= '0;
      dcause_q   <= '0;
      depc_q     <= '0;
      deps_q     <= '0;
      vecbase_q  <= STATIC_BASE;
      target_q   <= '0;
      redirect_q <= 1'b0;
    end else begin
      redirect_q <= redirect_d;
      if (ps_en)           ps_q      <= ps_d;
      if (epc1_en)         epc1_q    <= fault_pc_i;
      if (cause_en)        cause_q   <= cause_i;
      if (vaddr_en)        vaddr_q   <= vaddr_i;
      if (redirect_d)      target_q  <= target_i;
      if (vecbase_wr_en_i) vecbase_q <= vecbase_wr_data_i;
      if (dbg_hit) begin
        dcause_q <= cause_i;
        depc_q   <= fault_pc_i;
        deps_q   <= ps_q;
      end
    end
  end

  generate
    if (HAS_DBL_SAVE) begin : g_dbl
      logic [XLEN-1:0] dbl_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      dbl_q <= '0;
        else if (dbl_hit) dbl_q <= fault_pc_i;
      end
      assign dbl_epc_o = dbl_q;
    end else begin : g_no_dbl
      assign dbl_epc_o = '0;
    end
  endgenerate

  assign redirect_o  = redirect_q;
  assign target_pc_o = target_q;
  assign ps_o        = ps_q;
  assign epc1_o      = epc1_q;
  assign exc_cause_o = cause_q;
  assign exc_vaddr_o = vaddr_q;
  assign dbg_cause_o = dcause_q;
  assign dbg_epc_o   = depc_q;
  assign dbg_eps_o   = deps_q;
  assign vecbase_o   = vecbase_q;
endmodule

// File: rtl/trap_entry.sv
module trap_entry
  import trap_pkg::*;
#(
  parameter int unsigned     XLEN         = 32,
  parameter int unsigned     CAUSE_W      = 6,
  parameter int unsigned     DBG_LEVEL    = 6,
  parameter int unsigned     EXCM_LEVEL   = 3,
  parameter bit              HAS_DBL_SAVE = 1'b1,
  parameter bit              RELOC_EN     = 1'b1,
  parameter logic [XLEN-1:0] STATIC_BASE  = 32'h4000_0000,
  parameter logic [XLEN-1:0] VEC_KERNEL   = 32'h4000_0300,
  parameter logic [XLEN-1:0] VEC_USER     = 32'h4000_0340,
  parameter logic [XLEN-1:0] VEC_DOUBLE   = 32'h4000_03C0,
  parameter logic [XLEN-1:0] VEC_DEBUG    = 32'h4000_0280
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exc_req_i,
  input  logic               dbg_req_i,
  input  logic [XLEN-1:0]    fault_pc_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    vaddr_i,
  input  logic               vaddr_vld_i,
  input  logic               ps_wr_en_i,
  input  logic [5:0]         ps_wr_data_i,
  input  logic               vecbase_wr_en_i,
  input  logic [XLEN-1:0]    vecbase_wr_data_i,
  output logic               redirect_o,
  output logic [XLEN-1:0]    target_pc_o,
  output logic [5:0]         ps_o,
  output logic [XLEN-1:0]    epc1_o,
  output logic [XLEN-1:0]    dbl_epc_o,
  output logic [CAUSE_W-1:0] exc_cause_o,
  output logic [XLEN-1:0]    exc_vaddr_o,
  output logic [CAUSE_W-1:0] dbg_cause_o,
  output logic [XLEN-1:0]    dbg_epc_o,
  output logic [5:0]         dbg_eps_o,
  output logic [XLEN-1:0]    vecbase_o
);
  entry_kind_e     kind;
  logic [XLEN-1:0] target;

  trap_classify #(
    .DBG_LEVEL (DBG_LEVEL),
    .EXCM_LEVEL(EXCM_LEVEL)
  ) classify_i (
    .exc_req_i(exc_req_i),
    .dbg_req_i(dbg_req_i),
    .ps_i     (ps_o),
    .kind_o   (kind)
  );

  trap_vector_sel #(
    .XLEN       (XLEN),
    .RELOC_EN   (RELOC_EN),
    .STATIC_BASE(STATIC_BASE),
    .VEC_KERNEL (VEC_KERNEL),
    .VEC_USER   (VEC_USER),
    .VEC_DOUBLE (VEC_DOUBLE),
    .VEC_DEBUG  (VEC_DEBUG)
  ) vecsel_i (
    .kind_i   (kind),
    .vecbase_i(vecbase_o),
    .target_o (target)
  );

  trap_state_regs #(
    .XLEN        (XLEN),
    .CAUSE_W     (CAUSE_W),
    .DBG_LEVEL   (DBG_LEVEL),
    .HAS_DBL_SAVE(HAS_DBL_SAVE),
    .STATIC_BASE (STATIC_BASE)
  ) regs_i (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .kind_i           (kind),
    .target_i         (target),
    .fault_pc_i       (fault_pc_i),
    .cause_i          (cause_i),
    .vaddr_i          (vaddr_i),
    .vaddr_vld_i      (vaddr_vld_i),
    .ps_wr_en_i       (ps_wr_en_i),
    .ps_wr_data_i     (ps_wr_data_i),
    .vecbase_wr_en_i  (vecbase_wr_en_i),
    .vecbase_wr_data_i(vecbase_wr_data_i),
    .redirect_o       (redirect_o),
    .target_pc_o      (target_pc_o),
    .ps_o             (ps_o),
    .epc1_o           (epc1_o),
    .dbl_epc_o        (dbl_epc_o),
    .exc_cause_o      (exc_cause_o),
    .exc_vaddr_o      (exc_vaddr_o),
    .dbg_cause_o      (dbg_cause_o),
    .dbg_epc_o        (dbg_epc_o),
    .dbg_eps_o        (dbg_eps_o),
    .vecbase_o        (vecbase_o)
  );
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int unsigned XLEN         = 32,
  parameter int unsigned CAUSE_W      = 6,
  parameter int unsigned DBG_LEVEL    = 6,
  parameter int unsigned EXCM_LEVEL   = 3,
  parameter bit          HAS_DBL_SAVE = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               exc_req_i,
  input logic               dbg_req_i,
  input logic [XLEN-1:0]    fault_pc_i,
  input logic [CAUSE_W-1:0] cause_i,
  input logic               vaddr_vld_i,
  input logic               ps_wr_en_i,
  input logic               redirect_o,
  input logic [5:0]         ps_o,
  input logic [XLEN-1:0]    epc1_o,
  input logic [XLEN-1:0]    dbl_epc_o,
  input logic [CAUSE_W-1:0] exc_cause_o,
  input logic [XLEN-1:0]    exc_vaddr_o,
  input logic [XLEN-1:0]    dbg_epc_o
);
  logic       pv;
  logic [3:0] eff;
  logic       dbg_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pv <= 1'b0;
    else         pv <= 1'b1;
  end

  always_comb begin
    eff = ps_o[3:0];
    if (ps_o[4] && (eff < 4'(EXCM_LEVEL))) eff = 4'(EXCM_LEVEL);
  end
  assign dbg_ok = dbg_req_i && (eff < 4'(DBG_LEVEL));

  // R10
  redirect_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv && redirect_o |-> $past(exc_req_i || dbg_req_i));

  // R2
  kernel_user_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv && $past(exc_req_i && !dbg_req_i && !ps_o[4]) |->
      (epc1_o == $past(fault_pc_i)) && redirect_o);

  // R3
  double_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv && $past(exc_req_i && !dbg_req_i && ps_o[4]) |->
      (HAS_DBL_SAVE ? (dbl_epc_o == $past(fault_pc_i)) : (epc1_o == $past(fault_pc_i))));

  // R4
  cause_excm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv && $past(exc_req_i && !dbg_ok) |->
      ps_o[4] && (exc_cause_o == $past(cause_i)) && (ps_o[3:0] == $past(ps_o[3:0])));

  // R5
  vaddr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv && $past(!(exc_req_i && vaddr_vld_i && !dbg_ok)) |-> $stable(exc_vaddr_o));

  // R6
  debug_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv && $past(dbg_req_i && !dbg_ok && !exc_req_i && !ps_wr_en_i) |->
      !redirect_o && $stable(ps_o));

  // R7
  debug_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv && $past(dbg_ok) |->
      (ps_o[3:0] == 4'(DBG_LEVEL)) && ps_o[4] && (dbg_epc_o == $past(fault_pc_i)));

  // R8
  debug_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv && $past(dbg_ok && exc_req_i) |-> $stable(exc_cause_o) && $stable(epc1_o));
endmodule

bind trap_entry trap_entry_chk #(
  .XLEN        (XLEN),
  .CAUSE_W     (CAUSE_W),
  .DBG_LEVEL   (DBG_LEVEL),
  .EXCM_LEVEL  (EXCM_LEVEL),
  .HAS_DBL_SAVE(HAS_DBL_SAVE)
) chk_i (.*);

// File: tb/trap_entry_tb_top.sv
`timescale 1ns/1ps
module trap_entry_tb_top;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [31:0] VK = 32'h4000_0300, VU = 32'h4000_0340;
  localparam logic [31:0] VD = 32'h4000_03C0, VG = 32'h4000_0280;
  localparam int DBG = 6, EXL = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic exc_req, dbg_req, vaddr_vld, ps_wr_en, vb_wr_en;
  logic [31:0] pc, vaddr, vb_wr_data;
  logic [5:0]  cause, ps_wr_data;

  logic        o_redir [2];
  logic [31:0] o_tgt [2], o_epc1 [2], o_dbl [2], o_vaddr [2], o_depc [2], o_vb [2];
  logic [5:0]  o_ps [2], o_cause [2], o_dcause [2], o_deps [2];

  logic [31:0] m_tgt [2], m_epc1 [2], m_dbl [2], m_vaddr [2], m_depc [2], m_vb [2];
  logic [5:0]  m_ps [2], m_cause [2], m_dcause [2], m_deps [2];
  bit          m_redir [2];

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trap_entry #(.RELOC_EN(1'b1), .HAS_DBL_SAVE(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .exc_req_i(exc_req), .dbg_req_i(dbg_req),
    .fault_pc_i(pc), .cause_i(cause), .vaddr_i(vaddr), .vaddr_vld_i(vaddr_vld),
    .ps_wr_en_i(ps_wr_en), .ps_wr_data_i(ps_wr_data),
    .vecbase_wr_en_i(vb_wr_en), .vecbase_wr_data_i(vb_wr_data),
    .redirect_o(o_redir[0]), .target_pc_o(o_tgt[0]), .ps_o(o_ps[0]),
    .epc1_o(o_epc1[0]), .dbl_epc_o(o_dbl[0]), .exc_cause_o(o_cause[0]),
    .exc_vaddr_o(o_vaddr[0]), .dbg_cause_o(o_dcause[0]), .dbg_epc_o(o_depc[0]),
    .dbg_eps_o(o_deps[0]), .vecbase_o(o_vb[0]));

  trap_entry #(.RELOC_EN(1'b0), .HAS_DBL_SAVE(1'b0)) dut_fix_i (
    .clk_i(clk), .rst_ni(rst_n), .exc_req_i(exc_req), .dbg_req_i(dbg_req),
    .fault_pc_i(pc), .cause_i(cause), .vaddr_i(vaddr), .vaddr_vld_i(vaddr_vld),
    .ps_wr_en_i(ps_wr_en), .ps_wr_data_i(ps_wr_data),
    .vecbase_wr_en_i(vb_wr_en), .vecbase_wr_data_i(vb_wr_data),
    .redirect_o(o_redir[1]), .target_pc_o(o_tgt[1]), .ps_o(o_ps[1]),
    .epc1_o(o_epc1[1]), .dbl_epc_o(o_dbl[1]), .exc_cause_o(o_cause[1]),
    .exc_vaddr_o(o_vaddr[1]), .dbg_cause_o(o_dcause[1]), .dbg_epc_o(o_depc[1]),
    .dbg_eps_o(o_deps[1]), .vecbase_o(o_vb[1]));

  task automatic cmp(string req, string what, int d, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s dut%0d %s actual=%h expected=%h", req, d, what, act, exp);
    end
  endtask

  // model of one request for instance d (0: relocating, double save; 1: neither)
  task automatic model_req(int d, bit er, bit dr, bit vv);
    logic [3:0]  eff;
    logic [31:0] vec;
    eff = m_ps[d][3:0];
    if (m_ps[d][4] && eff < 4'(EXL)) eff = 4'(EXL);
    m_redir[d] = 1'b0;
    vec = '0;
    if (dr && eff < 4'(DBG)) begin
      m_dcause[d] = cause; m_depc[d] = pc; m_deps[d] = m_ps[d];
      m_ps[d] = {m_ps[d][5], 1'b1, 4'(DBG)};
      vec = VG; m_redir[d] = 1'b1;
    end else if (er) begin
      if (m_ps[d][4]) begin
        if (d == 0) m_dbl[d] = pc; else m_epc1[d] = pc;
        vec = VD;
      end else begin
        m_epc1[d] = pc;
        vec = m_ps[d][5] ? VU : VK;
      end
      m_cause[d] = cause;
      if (vv) m_vaddr[d] = vaddr;
      m_ps[d][4] = 1'b1;
      m_redir[d] = 1'b1;
    end
    if (m_redir[d]) m_tgt[d] = (d == 0) ? (vec - BASE + m_vb[d]) : vec;
  endtask

  task automatic cmp_all(int d, string rsave, string rcause, string rdbg);
    cmp("R10", "redirect", d, 32'(o_redir[d]), 32'(m_redir[d]));
    if (m_redir[d]) cmp("R9", "target", d, o_tgt[d], m_tgt[d]);
    cmp(rcause, "ps", d, 32'(o_ps[d]), 32'(m_ps[d]));
    cmp(rsave, "epc1", d, o_epc1[d], m_epc1[d]);
    cmp(rsave, "dbl_epc", d, o_dbl[d], m_dbl[d]);
    cmp(rcause, "cause", d, 32'(o_cause[d]), 32'(m_cause[d]));
    cmp("R5", "vaddr", d, o_vaddr[d], m_vaddr[d]);
    cmp(rdbg, "dbg_cause", d, 32'(o_dcause[d]), 32'(m_dcause[d]));
    cmp(rdbg, "dbg_epc", d, o_depc[d], m_depc[d]);
    cmp(rdbg, "dbg_eps", d, 32'(o_deps[d]), 32'(m_deps[d]));
    cmp("R11", "vecbase", d, o_vb[d], m_vb[d]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; exc_req = 0; dbg_req = 0; vaddr_vld = 0; ps_wr_en = 0; vb_wr_en = 0;
    pc = '0; vaddr = '0; vb_wr_data = '0; cause = '0; ps_wr_data = '0;
    for (int d = 0; d < 2; d++) begin
      m_tgt[d] = '0; m_epc1[d] = '0; m_dbl[d] = '0; m_vaddr[d] = '0; m_depc[d] = '0;
      m_vb[d] = BASE; m_ps[d] = 6'h10; m_cause[d] = '0; m_dcause[d] = '0;
      m_deps[d] = '0; m_redir[d] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 2; d++) cmp_all(d, "R1", "R1", "R1");

    for (int it = 0; it < 256; it++) begin
      automatic int sc = it % 4;
      automatic logic [5:0] psw = 6'(it / 4);
      automatic logic [31:0] vb = 32'h8000_0000 + 32'(it) * 32'h100;
      @(negedge clk);
      ps_wr_en = 1; ps_wr_data = psw; vb_wr_en = 1; vb_wr_data = vb;
      @(negedge clk);
      ps_wr_en = 0; vb_wr_en = 0;
      for (int d = 0; d < 2; d++) begin
        cmp("R10", "redirect idle", d, 32'(o_redir[d]), 32'd0);
        m_ps[d] = psw; m_vb[d] = vb;
      end
      pc = 32'h1000_0000 + 32'(it) * 4;
      cause = 6'(it * 7 + 1);
      vaddr = 32'hA000_0000 ^ 32'(it);
      exc_req   = (sc == 0) || (sc == 1) || (sc == 3);
      dbg_req   = (sc == 2) || (sc == 3);
      vaddr_vld = (sc == 0) || (sc == 3);
      for (int d = 0; d < 2; d++) model_req(d, exc_req, dbg_req, vaddr_vld);
      @(negedge clk);
      exc_req = 0; dbg_req = 0; vaddr_vld = 0;
      for (int d = 0; d < 2; d++) begin
        string rs, rc, rd;
        rs = psw[4] ? "R3" : "R2";
        rc = "R4"; rd = "R7";
        if (sc == 2) begin rs = "R6"; rc = "R6"; rd = "R6"; end
        if (sc == 3) begin rs = "R8"; rc = "R8"; rd = "R8"; end
        cmp_all(d, rs, rc, rd);
      end
    end

    // R11: status write and general request in the same cycle
    @(negedge clk);
    ps_wr_en = 1; ps_wr_data = 6'h02;
    @(negedge clk);
    for (int d = 0; d < 2; d++) m_ps[d] = 6'h02;
    ps_wr_data = 6'h23; pc = 32'h2222_0000; cause = 6'h15; exc_req = 1;
    for (int d = 0; d < 2; d++) model_req(d, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    ps_wr_en = 0; exc_req = 0;
    for (int d = 0; d < 2; d++) cmp_all(d, "R11", "R11", "R7");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule